// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block watches over software running on the clock that drives it. A free-running counter advances on every clock edge while the watchdog is enabled. If software lets the counter reach its limit, the block raises a system reset request. The request stays high until the external reset sequencer resets the block. To restart the count, software must write two key bytes in sequence to a single service address. The first key is `0x55`, which arms the sequence. The second key is `0xAA`, which restarts the count.

The timeout base is `2^BASE_LOG2` clock edges, with a default of 2^15. A two-bit rate input scales this base by 1, 4, 16 or 64. The block captures the rate only during a short protected window after reset. It captures the enable only on the first clock edge after reset. After that, changes to either input wait for the next reset.

Top module: `wdt_keyed`

## Requirements
- R1: While rst_ni is low, rst_req_o is low and the internal counter, the armed state and the captured configuration are cleared.
- R2: With the watchdog enabled and no service, rst_req_o first reads high after exactly 2^(BASE_LOG2+2*rate) + 1 rising edges following reset release. The rate encodings are 00 = x1, 01 = x4, 10 = x16 and 11 = x64. The first edge latches the enable, and the counter starts from zero on the edges after it.
- R3: A write of 0x55 to address SVC_ADDR arms the sequence. A later write of 0xAA to SVC_ADDR while armed restarts the count on that edge, so the request follows 2^(BASE_LOG2+2*rate) edges later. A repeated 0x55 keeps the sequence armed.
- R4: A write of 0xAA to SVC_ADDR while not armed does not restart the count.
- R5: A write of any value other than 0x55 or 0xAA to SVC_ADDR disarms the sequence, so a following 0xAA does not restart the count.
- R6: Writes to any address other than SVC_ADDR neither arm nor disarm the sequence.
- R7: The enable is latched from cfg_disable_i on the first rising edge after reset release, where 0 means enabled. When disabled, rst_req_o never rises.
- R8: Changes to cfg_disable_i after that first edge have no effect until the next reset.
- R9: rate_sel_i is captured on each of the first WIN_CYCLES edges after reset release, and the last captured value holds. Later changes are ignored until the next reset.
- R10: Once high, rst_req_o stays high until reset, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data byte |
| cfg_disable_i | input | 1 | 1 disables the watchdog; latched after reset |
| rate_sel_i | input | 2 | Timeout scale select; captured in the post-reset window |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The bench counts the exact number of edges to the request for every rate code. This catches a limit that is off by one or a rate that is decoded wrongly.

It also drives key sequences that must not restart the count:
- a lone 0xAA;
- 0x55 followed by a foreign value;
- 0x55 written to the wrong address.

A design that restarts the count on any of these would push the expected request later. A design in which a write to another address disarms the sequence would miss a legitimate restart.

Two further checks cover the enable and the rate. The bench toggles cfg_disable_i and rate_sel_i after their capture points, which would expose a design that follows these inputs live. Finally, the bench writes a full key sequence after the request has risen, which would reveal a request that a service can clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  typedef logic [1:0] rate_t;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SVC_ADDR = 6'h3a
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              svc_o
);
  logic armed_q;
  logic hit;

  assign hit   = wr_en_i && (wr_addr_i == ADDR_W'(SVC_ADDR));
  assign svc_o = hit && armed_q && (wr_data_i == KEY_FIRE);

  // any write to the service address re-decides the armed state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  armed_q <= 1'b0;
    else if (hit) armed_q <= (wr_data_i == KEY_ARM);
  end
endmodule

// File: rtl/wdt_cfg_latch.sv
module wdt_cfg_latch
  import wdt_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 64
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cfg_disable_i,
  input  rate_t rate_sel_i,
  output logic  loaded_o,
  output logic  en_o,
  output logic  win_done_o,
  output rate_t rate_o
);
  localparam int unsigned WW = $clog2(WIN_CYCLES + 1);

  logic [WW-1:0] win_q;
  logic          loaded_q, en_q;
  rate_t         rate_q;

  assign win_done_o = (win_q == WW'(WIN_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      en_q     <= 1'b0;
    end else if (!loaded_q) begin
      loaded_q <= 1'b1;
      en_q     <= !cfg_disable_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      rate_q <= '0;
    end else if (!win_done_o) begin
      win_q  <= win_q + WW'(1);
      rate_q <= rate_sel_i;
    end
  end

  assign loaded_o = loaded_q;
  assign en_o     = en_q;
  assign rate_o   = rate_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 15,
  localparam int unsigned CW = BASE_LOG2 + 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          svc_i,
  input  rate_t         rate_i,
  output logic [CW-1:0] cnt_o,
  output logic          req_o
);
  logic [CW-1:0] cnt_q, lim_m1;
  logic          req_q;

  always_comb lim_m1 = (CW'(1) << (BASE_LOG2 + 2 * int'(rate_i))) - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (en_i && !req_q) begin
      if (svc_i)                cnt_q <= '0;
      else if (cnt_q >= lim_m1) req_q <= 1'b1;
      else                      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign req_o = req_q;
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned SVC_ADDR   = 6'h3a,
  parameter int unsigned BASE_LOG2  = 15,
  parameter int unsigned WIN_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              cfg_disable_i,
  input  logic [1:0]        rate_sel_i,
  output logic              rst_req_o
);
  localparam int unsigned CW = BASE_LOG2 + 7;

  logic          svc, loaded, en, win_done;
  rate_t         rate;
  logic [CW-1:0] cnt;

  wdt_key_seq #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_key (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .svc_o(svc)
  );

  wdt_cfg_latch #(.WIN_CYCLES(WIN_CYCLES)) u_cfg (
    .clk_i, .rst_ni, .cfg_disable_i, .rate_sel_i,
    .loaded_o(loaded), .en_o(en), .win_done_o(win_done), .rate_o(rate)
  );

  wdt_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk_i, .rst_ni, .en_i(en), .svc_i(svc), .rate_i(rate),
    .cnt_o(cnt), .req_o(rst_req_o)
  );
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int unsigned BASE_LOG2 = 15,
  parameter int unsigned CW = BASE_LOG2 + 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rst_req_o,
  input logic          loaded,
  input logic          en,
  input logic          win_done,
  input logic [1:0]    rate,
  input logic          svc,
  input logic [CW-1:0] cnt
);
  logic [CW-1:0] exp_lim;
  always_comb begin
    exp_lim = '0;
    exp_lim[BASE_LOG2 + 2 * int'(rate)] = 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded |-> (!rst_req_o && cnt == '0));
  assert_req_at_limit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> (cnt + CW'(1) == exp_lim));
  assert_service_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc && en && !rst_req_o) |=> (cnt == '0));
  assert_disabled_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded && !en) |-> !rst_req_o);
  assert_enable_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded |=> $stable(en));
  assert_rate_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_done |=> $stable(rate));
  assert_req_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);
endmodule

bind wdt_keyed wdt_keyed_chk #(.BASE_LOG2(BASE_LOG2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rst_req_o(rst_req_o), .loaded(loaded),
  .en(en), .win_done(win_done), .rate(rate), .svc(svc), .cnt(cnt)
);

// File: tb/sim_wdt_keyed.sv
`timescale 1ns/1ps
module sim_wdt_keyed;
  localparam int unsigned AW = 4;
  localparam int unsigned SA = 4'hA;
  localparam int unsigned B  = 4;
  localparam int unsigned W  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          cfg_dis = 1'b0;
  logic [1:0]    rate = '0;
  logic          req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdt_keyed #(.ADDR_W(AW), .SVC_ADDR(SA), .BASE_LOG2(B), .WIN_CYCLES(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cfg_disable_i(cfg_dis), .rate_sel_i(rate),
    .rst_req_o(req)
  );

  function automatic int lim(input int r);
    return 1 << (B + 2 * r);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic dis, input logic [1:0] r);
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    cfg_dis = dis;
    rate = r;
    #12;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic edges_to_req(input int maxn, output int n);
    n = 0;
    while (!req && n < maxn) begin
      step();
      n++;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    // R1
    #7;
    chk("R1 req during reset", int'(req), 0);
    do_reset(1'b0, 2'd0);
    chk("R1 req after release", int'(req), 0);

    // R2: full rate sweep
    for (int r = 0; r < 4; r++) begin
      do_reset(1'b0, 2'(r));
      edges_to_req(5000, n);
      chk($sformatf("R2 rate %0d edges", r), n, lim(r) + 1);
    end

    // R3: service after a few edges
    do_reset(1'b0, 2'd0);
    for (int i = 0; i < 5; i++) step();
    wr(AW'(SA), 8'h55);
    wr(AW'(SA), 8'hAA);
    edges_to_req(5000, n);
    chk("R3 restart", n, lim(0));

    // R3: repeated services hold off the request
    do_reset(1'b0, 2'd1);
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 50; i++) step();
      wr(AW'(SA), 8'h55);
      wr(AW'(SA), 8'hAA);
    end
    chk("R3 held off", int'(req), 0);
    edges_to_req(5000, n);
    chk("R3 after last service", n, lim(1));

    // R3: double arm byte stays armed
    do_reset(1'b0, 2'd0);
    step();
    wr(AW'(SA), 8'h55);
    wr(AW'(SA), 8'h55);
    wr(AW'(SA), 8'hAA);
    edges_to_req(5000, n);
    chk("R3 double arm", n, lim(0));

    // R4: lone fire byte
    do_reset(1'b0, 2'd0);
    for (int i = 0; i < 3; i++) step();
    wr(AW'(SA), 8'hAA);
    edges_to_req(5000, n);
    chk("R4 lone AA", n, lim(0) + 1 - 4);

    // R5: foreign byte disarms
    do_reset(1'b0, 2'd0);
    step();
    step();
    wr(AW'(SA), 8'h55);
    wr(AW'(SA), 8'h5A);
    wr(AW'(SA), 8'hAA);
    edges_to_req(5000, n);
    chk("R5 foreign byte", n, lim(0) + 1 - 5);

    // R6: arm byte at wrong address does not arm
    do_reset(1'b0, 2'd0);
    step();
    step();
    wr(AW'(3), 8'h55);
    wr(AW'(SA), 8'hAA);
    edges_to_req(5000, n);
    chk("R6 wrong-address arm", n, lim(0) + 1 - 4);

    // R6: write elsewhere does not disarm
    do_reset(1'b0, 2'd0);
    step();
    step();
    wr(AW'(SA), 8'h55);
    wr(AW'(3), 8'h00);
    wr(AW'(SA), 8'hAA);
    edges_to_req(5000, n);
    chk("R6 other address ignored", n, lim(0));

    // R7: disabled never fires
    do_reset(1'b1, 2'd0);
    edges_to_req(300, n);
    chk("R7 disabled", int'(req), 0);

    // R8: late disable ignored
    do_reset(1'b0, 2'd0);
    step();
    cfg_dis = 1'b1;
    edges_to_req(5000, n);
    chk("R8 late disable", n, lim(0));

    // R8: late enable ignored, then reset makes it effective
    do_reset(1'b1, 2'd0);
    step();
    cfg_dis = 1'b0;
    edges_to_req(300, n);
    chk("R8 late enable", int'(req), 0);
    do_reset(1'b0, 2'd0);
    edges_to_req(5000, n);
    chk("R8 enable after reset", n, lim(0) + 1);

    // R9: change after window ignored
    do_reset(1'b0, 2'd0);
    for (int i = 0; i < W; i++) step();
    rate = 2'd3;
    edges_to_req(5000, n);
    chk("R9 late rate", n, lim(0) + 1 - W);

    // R9: change inside window taken
    do_reset(1'b0, 2'd0);
    step();
    step();
    rate = 2'd1;
    edges_to_req(5000, n);
    chk("R9 in-window rate", n, lim(1) + 1 - 2);

    // R10: request sticky against service
    wr(AW'(SA), 8'h55);
    wr(AW'(SA), 8'hAA);
    for (int i = 0; i < 10; i++) step();
    chk("R10 sticky", int'(req), 1);
    do_reset(1'b0, 2'd0);
    chk("R1 req cleared by reset", int'(req), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule